// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps wall-clock time and the calendar date in packed-BCD registers. It advances once for each pulse on a one-second tick input, which is supplied from outside. Eight byte-wide registers hold the time: seconds, minutes, hours, date, month, two-digit year, day of week and a century byte. Hours run in either 24-hour or 12-hour form. In 12-hour form a separate bit marks PM.

The host reads and writes these registers byte by byte through plain strobes. A read session begins with `rd_start`, which copies the whole live register set into a snapshot latch. `rd_data` then always returns the selected byte of that snapshot, while the live counter keeps running. Writes never reach the live counter directly. Each written byte lands in a staging buffer, and a per-byte mask records which bytes were written. A `commit` pulse, issued by the bus layer on a valid stop, copies only the marked bytes into the live counter. An `abort` pulse throws away everything that was staged.

After reset, which stands for a loss of all power, the counter does not advance and `clock_fail` reads 1. The first commit that carries at least one byte clears the flag and starts the counter. None of these strobes can be back-pressured: each one takes effect on the clock edge where it is seen high.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds (address 0) and minutes (address 1) count BCD 00..59. Seconds wrap 59→00 and carry into minutes, and minutes wrap 59→00 and carry into the hour.
- R2: When hour bit 7 is 1 (24-hour mode), hour bits 5:0 count BCD 00..23. A wrap from 23 to 00 advances the date.
- R3: When hour bit 7 is 0 (12-hour mode), hour bits 4:0 count BCD 01..12 and hour bit 5 is the PM flag. Going from 11 to 12 toggles PM, and 12 goes to 01. Going from 11 PM to 12 AM advances the date.
- R4: Date (address 3) wraps to 01 and advances the month (address 4) after day 31. It does so after day 30 for months 04, 06, 09 and 11. For month 02 it does so after day 29 when the year (address 5) is divisible by 4, and after day 28 otherwise. Month wraps 12→01 and advances the year.
- R5: Day of week (address 6, bits 2:0) steps 0→1→…→6→0 once each time the date advances.
- R6: The year wraps 99→00 and moves the century byte (address 7) from 19 to 20; at 20 it stays 20. A committed century value other than BCD 19 or 20 is ignored.
- R7: `rd_start` copies all eight live registers into the snapshot. `rd_data` shows snapshot byte `rd_addr` and does not change as the live counter advances.
- R8: Written bytes reach the live counter only on `commit`. `abort` discards all staged bytes, so a later commit changes nothing.
- R9: A commit loads the marked bytes on its own edge and takes precedence over a tick on that same edge. Counting resumes from the new value at the next tick.
- R10: After reset `clock_fail` is 1 and ticks do not advance the time. A commit that carries at least one byte clears `clock_fail` and lets the counter run.
- R11: Reset values are: seconds 00, minutes 00, hour 0x12 (12-hour mode, AM, 12 o'clock), date 01, month 01, year 00, day of week 0, century 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; models total power loss |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Stage `wr_data` into the buffer slot `wr_addr` |
| wr_addr | input | 3 | Register index for a staged write |
| wr_data | input | 8 | Byte to stage |
| commit | input | 1 | Valid-stop strobe: apply staged bytes |
| abort | input | 1 | Invalid-transfer strobe: discard staged bytes |
| rd_start | input | 1 | Begin a read: capture the snapshot |
| rd_addr | input | 3 | Snapshot byte to show on `rd_data` |
| rd_data | output | 8 | Selected snapshot byte |
| clock_fail | output | 1 | 1 while the time is invalid after power loss |

## Verification
The bench drives the carry chain through its far corners:
- A full 23:59:59 on 31 December 99 under century 19 must ripple through every field at once; a missing carry stage leaves one field stale.
- February is tested with the year on either side of divisible-by-4, along with a 30-day month. A wrong month-length table either skips day 29 or invents day 31.
- The 12-hour edges 11→12, 12→01 and 11 PM → 12 AM catch a design that toggles PM at the wrong hour or advances the date at noon.
- Abort followed by an empty commit, and a commit that coincides with a tick, expose a buffer that leaks or a tick that overrides the new time.
- Reads taken after several ticks expose a snapshot that follows the live counter.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int NUM_REGS = 8;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int FLAT_W   = NUM_REGS * REG_W;

  localparam int IX_SEC   = 0;
  localparam int IX_MIN   = 1;
  localparam int IX_HOUR  = 2;
  localparam int IX_DATE  = 3;
  localparam int IX_MONTH = 4;
  localparam int IX_YEAR  = 5;
  localparam int IX_DOW   = 6;
  localparam int IX_CENT  = 7;

  localparam int H24_BIT  = 7;
  localparam int PM_BIT   = 5;
  localparam int DOW_W    = 3;

  localparam logic [7:0] CENT_OLD = 8'h19;
  localparam logic [7:0] CENT_NEW = 8'h20;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_cal_stage.sv
module bcd_cal_stage
  import bcd_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic                commit,
  input  logic                abort,
  output logic [FLAT_W-1:0]   stage_data,
  output logic [NUM_REGS-1:0] stage_mask
);
  logic flush;
  assign flush = commit | abort;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i)) && !flush;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_data[i*REG_W +: REG_W] <= '0;
        stage_mask[i]                <= 1'b0;
      end else begin
        if (hit) stage_data[i*REG_W +: REG_W] <= wr_data;
        if (flush)    stage_mask[i] <= 1'b0;
        else if (hit) stage_mask[i] <= 1'b1;
      end
    end
  end

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (stage_mask == '0));
  assert_write_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit && !abort) |=> stage_mask[$past(wr_addr)]);
endmodule

// File: rtl/bcd_cal_snap.sv
module bcd_cal_snap
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [FLAT_W-1:0] live,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic [FLAT_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (rd_start) snap_q <= live;
  end

  assign rd_data = snap_q[rd_addr*REG_W +: REG_W];

  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(snap_q));
  assert_snap_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (snap_q == $past(live)));
endmodule

// File: rtl/bcd_cal_core.sv
module bcd_cal_core
  import bcd_cal_pkg::*;
#(
  parameter logic [7:0] RESET_HOUR = 8'h12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                commit,
  input  logic [FLAT_W-1:0]   stage_data,
  input  logic [NUM_REGS-1:0] stage_mask,
  output logic [FLAT_W-1:0]   live,
  output logic                fail
);
  logic [7:0]       sec_q, min_q, hour_q, date_q, month_q, year_q, cent_q;
  logic [DOW_W-1:0] dow_q;

  logic [7:0]       sec_n, min_n, hour_n, date_n, month_n, year_n, cent_n;
  logic [DOW_W-1:0] dow_n;
  logic             c_sec, c_min, c_day, c_mon, c_year;
  logic [7:0]       hr_inc, last_day;

  function automatic logic [7:0] st(input int ix);
    return stage_data[ix*REG_W +: REG_W];
  endfunction

  always_comb begin
    c_sec = (sec_q == 8'h59);
    sec_n = c_sec ? 8'h00 : bcd_inc(sec_q);
    c_min = c_sec && (min_q == 8'h59);
    min_n = c_sec ? ((min_q == 8'h59) ? 8'h00 : bcd_inc(min_q)) : min_q;

    hour_n = hour_q;
    c_day  = 1'b0;
    hr_inc = 8'h00;
    if (c_min) begin
      if (hour_q[H24_BIT]) begin
        hr_inc = bcd_inc({2'b00, hour_q[5:0]});
        c_day  = (hour_q[5:0] == 6'h23);
        hour_n = {2'b10, c_day ? 6'h00 : hr_inc[5:0]};
      end else begin
        hr_inc = bcd_inc({3'b000, hour_q[4:0]});
        if (hour_q[4:0] == 5'h11) begin
          hour_n = {2'b00, ~hour_q[PM_BIT], 5'h12};
          c_day  = hour_q[PM_BIT];
        end else if (hour_q[4:0] == 5'h12) begin
          hour_n = {2'b00, hour_q[PM_BIT], 5'h01};
        end else begin
          hour_n = {2'b00, hour_q[PM_BIT], hr_inc[4:0]};
        end
      end
    end

    last_day = month_last_day(month_q, year_q);
    c_mon    = c_day && (date_q == last_day);
    date_n   = c_day ? (c_mon ? 8'h01 : bcd_inc(date_q)) : date_q;
    dow_n    = c_day ? ((dow_q == DOW_W'(6)) ? '0 : dow_q + DOW_W'(1)) : dow_q;
    c_year   = c_mon && (month_q == 8'h12);
    month_n  = c_mon ? ((month_q == 8'h12) ? 8'h01 : bcd_inc(month_q)) : month_q;
    year_n   = c_year ? ((year_q == 8'h99) ? 8'h00 : bcd_inc(year_q)) : year_q;
    cent_n   = (c_year && (year_q == 8'h99)) ? CENT_NEW : cent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hour_q <= RESET_HOUR;
      date_q <= 8'h01; month_q <= 8'h01; year_q <= 8'h00;
      dow_q <= '0; cent_q <= CENT_NEW; fail <= 1'b1;
    end else if (commit) begin
      if (stage_mask[IX_SEC])   sec_q   <= st(IX_SEC);
      if (stage_mask[IX_MIN])   min_q   <= st(IX_MIN);
      if (stage_mask[IX_HOUR])  hour_q  <= st(IX_HOUR);
      if (stage_mask[IX_DATE])  date_q  <= st(IX_DATE);
      if (stage_mask[IX_MONTH]) month_q <= st(IX_MONTH);
      if (stage_mask[IX_YEAR])  year_q  <= st(IX_YEAR);
      if (stage_mask[IX_DOW])   dow_q   <= stage_data[IX_DOW*REG_W +: DOW_W];
      if (stage_mask[IX_CENT] && (st(IX_CENT) == CENT_OLD || st(IX_CENT) == CENT_NEW))
        cent_q <= st(IX_CENT);
      if (|stage_mask) fail <= 1'b0;
    end else if (tick && !fail) begin
      sec_q <= sec_n; min_q <= min_n; hour_q <= hour_n; date_q <= date_n;
      month_q <= month_n; year_q <= year_n; dow_q <= dow_n; cent_q <= cent_n;
    end
  end

  assign live = {cent_q, {(REG_W-DOW_W){1'b0}}, dow_q, year_q, month_q,
                 date_q, hour_q, min_q, sec_q};

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !commit) |=> ($stable(sec_q) && $stable(min_q) && $stable(date_q)));
  assert_fail_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && |stage_mask) |=> !fail);
  assert_commit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && stage_mask[IX_SEC]) |=> (sec_q == $past(stage_data[7:0])));
  assert_dow_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !fail) |=> (dow_q <= DOW_W'(6)));
  assert_cent_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cent_q == CENT_OLD) || (cent_q == CENT_NEW));
  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fail && !commit && sec_q == 8'h59) |=> (sec_q == 8'h00));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter logic [7:0] RESET_HOUR = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              commit,
  input  logic              abort,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              clock_fail
);
  logic [FLAT_W-1:0]   stage_data;
  logic [NUM_REGS-1:0] stage_mask;
  logic [FLAT_W-1:0]   live;

  bcd_cal_stage u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .abort(abort), .stage_data(stage_data), .stage_mask(stage_mask)
  );

  bcd_cal_core #(.RESET_HOUR(RESET_HOUR)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .commit(commit),
    .stage_data(stage_data), .stage_mask(stage_mask), .live(live), .fail(clock_fail)
  );

  bcd_cal_snap u_snap (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .live(live),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic commit = 1'b0, abort = 1'b0, rd_start = 1'b0, clock_fail;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .abort(abort), .rd_start(rd_start),
    .rd_addr(rd_addr), .rd_data(rd_data), .clock_fail(clock_fail)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic stage(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic snap();
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    check(req, $sformatf("reg%0d", a), rd_data, exp);
  endtask

  task automatic set_all(input logic [7:0] s, m, h, d, mo, y, w, c);
    stage(3'd0, s); stage(3'd1, m); stage(3'd2, h); stage(3'd3, d);
    stage(3'd4, mo); stage(3'd5, y); stage(3'd6, w); stage(3'd7, c);
    pulse_commit();
  endtask

  task automatic t_reset();
    snap();
    check("R10", "fail after reset", {7'd0, clock_fail}, 8'h01);
    expect_reg("R11", 3'd0, 8'h00); expect_reg("R11", 3'd1, 8'h00);
    expect_reg("R11", 3'd2, 8'h12); expect_reg("R11", 3'd3, 8'h01);
    expect_reg("R11", 3'd4, 8'h01); expect_reg("R11", 3'd5, 8'h00);
    expect_reg("R11", 3'd6, 8'h00); expect_reg("R11", 3'd7, 8'h20);
    ticks(3); snap();
    expect_reg("R10", 3'd0, 8'h00);
  endtask

  task automatic t_first_write();
    stage(3'd0, 8'h58); pulse_commit();
    check("R10", "fail cleared", {7'd0, clock_fail}, 8'h00);
    ticks(1); snap(); expect_reg("R1", 3'd0, 8'h59);
    ticks(1); snap(); expect_reg("R1", 3'd0, 8'h00); expect_reg("R1", 3'd1, 8'h01);
  endtask

  task automatic t_abort();
    stage(3'd0, 8'h30); stage(3'd1, 8'h45);
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    pulse_commit(); snap();
    expect_reg("R8", 3'd0, 8'h00); expect_reg("R8", 3'd1, 8'h01);
  endtask

  task automatic t_full_roll();
    set_all(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06, 8'h19);
    ticks(1); snap();
    expect_reg("R1", 3'd0, 8'h00); expect_reg("R1", 3'd1, 8'h00);
    expect_reg("R2", 3'd2, 8'h80); expect_reg("R4", 3'd3, 8'h01);
    expect_reg("R4", 3'd4, 8'h01); expect_reg("R6", 3'd5, 8'h00);
    expect_reg("R5", 3'd6, 8'h00); expect_reg("R6", 3'd7, 8'h20);
    set_all(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h02, 8'h20);
    ticks(1); snap();
    expect_reg("R6", 3'd7, 8'h20); expect_reg("R5", 3'd6, 8'h03);
  endtask

  task automatic t_twelve_hour();
    set_all(8'h59, 8'h59, 8'h11, 8'h05, 8'h03, 8'h10, 8'h01, 8'h20);
    ticks(1); snap();
    expect_reg("R3", 3'd2, 8'h32); expect_reg("R3", 3'd3, 8'h05);
    set_all(8'h59, 8'h59, 8'h32, 8'h05, 8'h03, 8'h10, 8'h01, 8'h20);
    ticks(1); snap(); expect_reg("R3", 3'd2, 8'h21);
    set_all(8'h59, 8'h59, 8'h31, 8'h05, 8'h03, 8'h10, 8'h01, 8'h20);
    ticks(1); snap();
    expect_reg("R3", 3'd2, 8'h12); expect_reg("R3", 3'd3, 8'h06);
    expect_reg("R5", 3'd6, 8'h02);
  endtask

  task automatic t_months();
    set_all(8'h59, 8'h59, 8'h23 | 8'h80, 8'h28, 8'h02, 8'h23, 8'h00, 8'h20);
    ticks(1); snap(); expect_reg("R4", 3'd3, 8'h01); expect_reg("R4", 3'd4, 8'h03);
    set_all(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h00, 8'h20);
    ticks(1); snap(); expect_reg("R4", 3'd3, 8'h29); expect_reg("R4", 3'd4, 8'h02);
    set_all(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h00, 8'h20);
    ticks(1); snap(); expect_reg("R4", 3'd3, 8'h01); expect_reg("R4", 3'd4, 8'h03);
    set_all(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h24, 8'h00, 8'h20);
    ticks(1); snap(); expect_reg("R4", 3'd3, 8'h01); expect_reg("R4", 3'd4, 8'h05);
    set_all(8'h59, 8'h59, 8'hA3, 8'h30, 8'h07, 8'h24, 8'h00, 8'h20);
    ticks(1); snap(); expect_reg("R4", 3'd3, 8'h31);
  endtask

  task automatic t_snapshot();
    set_all(8'h10, 8'h20, 8'h85, 8'h15, 8'h06, 8'h30, 8'h03, 8'h20);
    snap(); ticks(4);
    expect_reg("R7", 3'd0, 8'h10);
    snap(); expect_reg("R7", 3'd0, 8'h14);
  endtask

  task automatic t_commit_tick();
    stage(3'd0, 8'h40);
    @(negedge clk); commit = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); commit = 1'b0; tick_1hz = 1'b0;
    snap(); expect_reg("R9", 3'd0, 8'h40);
    ticks(1); snap(); expect_reg("R9", 3'd0, 8'h41);
  endtask

  task automatic t_bad_century();
    stage(3'd7, 8'h21); pulse_commit(); snap();
    expect_reg("R6", 3'd7, 8'h20);
    stage(3'd7, 8'h19); pulse_commit(); snap();
    expect_reg("R6", 3'd7, 8'h19);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_write();
    t_abort();
    t_full_roll();
    t_twelve_hour();
    t_months();
    t_snapshot();
    t_commit_tick();
    t_bad_century();
    finish_run();
  end
endmodule